// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a bank of internal control and status registers through only two directly addressed host registers: a command register and a data register. The host starts each transfer with a single command write that sets a busy flag, a direction flag and an 8-bit register index. It then polls until the busy flag drops. A read leaves the selected internal register's value in the data register. A write delivers the value that the host placed in the data register beforehand.

Two internal slots do not hold plain storage. Slot 6 is a management access register and slot 7 is a management data register. Writing slot 6 with its go bit set issues a request toward a PHY, naming a 5-bit PHY address and a 5-bit PHY register. The request is held until the PHY stub acknowledges it. Address 1 selects the on-chip PHY and every other address selects the external PHY. The completion latency of the internal bank is a parameter.

Top module: `ind_csr_bridge`

## Requirements
- R1: After reset the command register, the data register and every internal slot read 0, and no management request is raised.
- R2: A host write to the command register (host_addr 0) with bit 31 set starts an access while idle. Bit 31 of the command register then reads 1 for exactly BANK_LAT cycles and then reads 0.
- R3: An access with bit 30 = 1 is a read. At completion, the data register (host_addr 1) holds the value of the internal slot named by bits 7:0.
- R4: An access with bit 30 = 0 is a write. At completion, the data register's value is stored in the named slot, and a later read of that slot returns it.
- R5: A command write while busy is ignored: the index and direction in flight do not change. The event sets a sticky error flag at command bit 29, and an idle command write with bit 29 = 1 clears that flag.
- R6: A host write to the data register while busy is dropped, and the data register keeps its value.
- R7: Slot indices at or above NUM_REGS read as 0, and writes to them change nothing.
- R8: Writing slot 6 with bit 0 = 1 raises mgmt_req with PHY address from bits 15:11, PHY register from bits 10:6, and write flag from bit 1. The request holds until mgmt_ack, and slot 6 bit 0 reads 1 until then.
- R9: mgmt_int_sel is 1 exactly when the requested PHY address equals 1.
- R10: For a management read (bit 1 = 0), mgmt_rdata is captured into slot 7 bits 15:0 on acknowledge. For a management write, mgmt_wdata carries slot 7 bits 15:0.
- R11: An idle command write with bit 31 clear starts no access, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = command register, 1 = data register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read value of the register selected by host_addr |
| mgmt_req | output | 1 | Management request pending |
| mgmt_wr | output | 1 | 1 = management write, 0 = management read |
| mgmt_phy | output | 5 | Requested PHY address |
| mgmt_reg | output | 5 | Requested PHY register |
| mgmt_wdata | output | 16 | Management write data |
| mgmt_int_sel | output | 1 | 1 selects the on-chip PHY |
| mgmt_ack | input | 1 | Management request completed |
| mgmt_rdata | input | 16 | Management read data returned with mgmt_ack |

## Verification
The hardest situations to reach from the ports are host writes that land inside the short busy window. Examples are a second command, or a data write that would corrupt an access in flight. The bench issues these back to back with the starting command, so they arrive while busy is still high at BANK_LAT = 3. A management request caught mid-flight is also hard to reach. The bench reads slot 6 through a full indirect access before the PHY stub acknowledges, and so observes the pending bit at the host port.

// File: rtl/ics_pkg.sv
package ics_pkg;
   localparam int unsigned CMD_W      = 32;
   localparam int unsigned IDX_W      = 8;
   localparam int unsigned BIT_BUSY   = 31;
   localparam int unsigned BIT_RNW    = 30;
   localparam int unsigned BIT_ERR    = 29;
   localparam logic [IDX_W-1:0] SLOT_MGMT_ACC = 8'h06;
   localparam logic [IDX_W-1:0] SLOT_MGMT_DAT = 8'h07;
   localparam int unsigned PHY_W = 5;
   localparam int unsigned MD_W  = 16;
   typedef enum logic {SEL_CMD = 1'b0, SEL_DATA = 1'b1} host_sel_e;
endpackage

// File: rtl/ics_lat_seq.sv
module ics_lat_seq #(
   parameter int unsigned LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int unsigned CW = $clog2(LAT + 1);
   localparam logic [CW-1:0] LAT_V = CW'(LAT);
   localparam logic [CW-1:0] ONE_V = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= LAT_V;
      else if (cnt_q != '0)   cnt_q <= cnt_q - ONE_V;
   end

   assign done = (cnt_q == ONE_V);

   a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (cnt_q == '0));
endmodule

// File: rtl/ics_mgmt_fwd.sv
module ics_mgmt_fwd
   import ics_pkg::*;
#(
   parameter logic [PHY_W-1:0] INT_PHY_ADDR = 5'd1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_we,
   input  logic                 dat_we,
   input  logic [CMD_W-1:0]     wdata,
   output logic [CMD_W-1:0]     acc_rd,
   output logic [CMD_W-1:0]     dat_rd,
   output logic                 mgmt_req,
   output logic                 mgmt_wr,
   output logic [PHY_W-1:0]     mgmt_phy,
   output logic [PHY_W-1:0]     mgmt_reg,
   output logic [MD_W-1:0]      mgmt_wdata,
   output logic                 mgmt_int_sel,
   input  logic                 mgmt_ack,
   input  logic [MD_W-1:0]      mgmt_rdata
);
   logic [PHY_W-1:0] phy_q, reg_q;
   logic             wnr_q, pend_q;
   logic [MD_W-1:0]  dat_q;
   logic             unused_hi;

   assign unused_hi = ^{wdata[31:16], wdata[5:2]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_q  <= '0;
         reg_q  <= '0;
         wnr_q  <= 1'b0;
         pend_q <= 1'b0;
         dat_q  <= '0;
      end else if (pend_q) begin
         if (mgmt_ack) begin
            pend_q <= 1'b0;
            if (!wnr_q) dat_q <= mgmt_rdata;
         end
      end else begin
         if (acc_we) begin
            phy_q  <= wdata[15:11];
            reg_q  <= wdata[10:6];
            wnr_q  <= wdata[1];
            pend_q <= wdata[0];
         end
         if (dat_we) dat_q <= wdata[MD_W-1:0];
      end
   end

   assign acc_rd       = {16'h0, phy_q, reg_q, 4'h0, wnr_q, pend_q};
   assign dat_rd       = {16'h0, dat_q};
   assign mgmt_req     = pend_q;
   assign mgmt_wr      = wnr_q;
   assign mgmt_phy     = phy_q;
   assign mgmt_reg     = reg_q;
   assign mgmt_wdata   = dat_q;
   assign mgmt_int_sel = (phy_q == INT_PHY_ADDR);

   a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_phy) && $stable(mgmt_reg)));
   a_r10_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_req && !mgmt_ack) |=> $stable(mgmt_wdata));
endmodule

// File: rtl/ics_reg_bank.sv
module ics_reg_bank
   import ics_pkg::*;
#(
   parameter int unsigned      NUM_REGS     = 16,
   parameter logic [PHY_W-1:0] INT_PHY_ADDR = 5'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [CMD_W-1:0]  wdata,
   output logic [CMD_W-1:0]  rdata,
   output logic              mgmt_req,
   output logic              mgmt_wr,
   output logic [PHY_W-1:0]  mgmt_phy,
   output logic [PHY_W-1:0]  mgmt_reg,
   output logic [MD_W-1:0]   mgmt_wdata,
   output logic              mgmt_int_sel,
   input  logic              mgmt_ack,
   input  logic [MD_W-1:0]   mgmt_rdata
);
   logic [CMD_W-1:0] slot_rd [NUM_REGS];
   logic [CMD_W-1:0] acc_rd, dat_rd;
   logic             acc_we, dat_we;

   assign acc_we = we && (idx == SLOT_MGMT_ACC);
   assign dat_we = we && (idx == SLOT_MGMT_DAT);

   ics_mgmt_fwd #(.INT_PHY_ADDR(INT_PHY_ADDR)) u_mgmt (
      .clk, .rst_n, .acc_we, .dat_we, .wdata, .acc_rd, .dat_rd,
      .mgmt_req, .mgmt_wr, .mgmt_phy, .mgmt_reg, .mgmt_wdata,
      .mgmt_int_sel, .mgmt_ack, .mgmt_rdata
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      if (i == int'(SLOT_MGMT_ACC)) begin : g_acc
         assign slot_rd[i] = acc_rd;
      end else if (i == int'(SLOT_MGMT_DAT)) begin : g_dat
         assign slot_rd[i] = dat_rd;
      end else begin : g_plain
         logic [CMD_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                          q <= '0;
            else if (we && idx == IDX_W'(i))    q <= wdata;
         end
         assign slot_rd[i] = q;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (idx == IDX_W'(k)) rdata = slot_rd[k];
   end
endmodule

// File: rtl/ics_host_if.sv
module ics_host_if
   import ics_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_addr,
   input  logic [CMD_W-1:0]  host_wdata,
   output logic [CMD_W-1:0]  host_rdata,
   input  logic              done,
   input  logic [CMD_W-1:0]  bank_rdata,
   output logic              start,
   output logic              bank_we,
   output logic [IDX_W-1:0]  acc_idx,
   output logic [CMD_W-1:0]  acc_wdata
);
   logic             busy_q, rnw_q, err_q;
   logic [IDX_W-1:0] idx_q;
   logic [CMD_W-1:0] data_q;
   logic             cmd_wr, dat_wr;
   logic             unused_mid;

   assign unused_mid = ^host_wdata[28:8];
   assign cmd_wr = host_wr && (host_addr == SEL_CMD);
   assign dat_wr = host_wr && (host_addr == SEL_DATA);
   assign start  = cmd_wr && !busy_q && host_wdata[BIT_BUSY];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rnw_q  <= 1'b0;
         err_q  <= 1'b0;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (cmd_wr) err_q  <= 1'b1;
         if (done)   busy_q <= 1'b0;
      end else if (cmd_wr) begin
         if (host_wdata[BIT_ERR]) err_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            rnw_q  <= host_wdata[BIT_RNW];
            idx_q  <= host_wdata[IDX_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    data_q <= '0;
      else if (done && rnw_q)        data_q <= bank_rdata;
      else if (dat_wr && !busy_q)    data_q <= host_wdata;
   end

   assign bank_we    = done && !rnw_q;
   assign acc_idx    = idx_q;
   assign acc_wdata  = data_q;
   assign host_rdata = (host_addr == SEL_DATA) ? data_q
                     : {busy_q, rnw_q, err_q, 21'h0, idx_q};

   a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_q);
   a_r2_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy_q);
   a_r2_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy_q);
   a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> ($stable(idx_q) && $stable(rnw_q) && busy_q));
   a_r6_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> $stable(data_q));
endmodule

// File: rtl/ind_csr_bridge.sv
module ind_csr_bridge
   import ics_pkg::*;
#(
   parameter int unsigned      BANK_LAT     = 3,
   parameter int unsigned      NUM_REGS     = 16,
   parameter logic [4:0]       INT_PHY_ADDR = 5'd1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_addr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        mgmt_req,
   output logic        mgmt_wr,
   output logic [4:0]  mgmt_phy,
   output logic [4:0]  mgmt_reg,
   output logic [15:0] mgmt_wdata,
   output logic        mgmt_int_sel,
   input  logic        mgmt_ack,
   input  logic [15:0] mgmt_rdata
);
   if (BANK_LAT < 1 || BANK_LAT > 15) begin : g_bad_lat
      $error("BANK_LAT must lie in 1..15");
   end
   if (NUM_REGS < 8 || NUM_REGS > 256) begin : g_bad_regs
      $error("NUM_REGS must lie in 8..256");
   end

   logic             start, done, bank_we;
   logic [IDX_W-1:0] acc_idx;
   logic [CMD_W-1:0] acc_wdata, bank_rdata;

   ics_host_if u_host (
      .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .host_rdata,
      .done, .bank_rdata, .start, .bank_we, .acc_idx, .acc_wdata
   );

   ics_lat_seq #(.LAT(BANK_LAT)) u_seq (
      .clk, .rst_n, .start, .done
   );

   ics_reg_bank #(.NUM_REGS(NUM_REGS), .INT_PHY_ADDR(INT_PHY_ADDR)) u_bank (
      .clk, .rst_n, .we(bank_we), .idx(acc_idx), .wdata(acc_wdata),
      .rdata(bank_rdata), .mgmt_req, .mgmt_wr, .mgmt_phy, .mgmt_reg,
      .mgmt_wdata, .mgmt_int_sel, .mgmt_ack, .mgmt_rdata
   );
endmodule

// File: tb/ind_csr_bridge_bench.sv
module ind_csr_bridge_bench;
   localparam int LAT  = 3;
   localparam int NREG = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_addr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mgmt_req, mgmt_wr, mgmt_int_sel;
   logic [4:0]  mgmt_phy, mgmt_reg;
   logic [15:0] mgmt_wdata;
   logic        mgmt_ack = 1'b0;
   logic [15:0] mgmt_rdata = '0;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ind_csr_bridge #(.BANK_LAT(LAT), .NUM_REGS(NREG)) u_ind_csr_bridge (
      .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .host_rdata,
      .mgmt_req, .mgmt_wr, .mgmt_phy, .mgmt_reg, .mgmt_wdata,
      .mgmt_int_sel, .mgmt_ack, .mgmt_rdata
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic a, output logic [31:0] v);
      host_addr = a; #1; v = host_rdata;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0; host_addr = 1'b0; #1;
      while (host_rdata[31] && cyc < 100) begin
         cyc++; @(negedge clk); #1;
      end
   endtask

   task automatic access(input logic rnw, input logic [7:0] idx, input string tag);
      int cyc;
      hwrite(1'b0, {1'b1, rnw, 22'h0, idx});
      wait_idle(cyc);
      chk(tag, cyc, LAT);
   endtask

   task automatic bank_wr(input logic [7:0] idx, input logic [31:0] d);
      hwrite(1'b1, d);
      access(1'b0, idx, "R2 busy length on write");
   endtask

   task automatic bank_rd(input logic [7:0] idx, output logic [31:0] v);
      access(1'b1, idx, "R2 busy length on read");
      hread(1'b1, v);
   endtask

   function automatic logic [31:0] pat(input int i);
      return {8'hC3, 8'(i), ~8'(i), 8'h5A};
   endfunction

   task automatic run();
      logic [31:0] v;
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      hread(1'b0, v); chk("R1 command after reset", v, 32'h0);
      hread(1'b1, v); chk("R1 data after reset", v, 32'h0);
      chk("R1 no request after reset", {31'h0, mgmt_req}, 32'h0);
      bank_rd(8'd3, v); chk("R1 slot 3 after reset", v, 32'h0);
      bank_rd(8'd7, v); chk("R1 slot 7 after reset", v, 32'h0);

      // R4 / R7 sweep writes, then R3 sweep reads
      for (int i = 0; i < 16; i++)
         if (i != 6 && i != 7) bank_wr(8'(i), pat(i));
      bank_wr(8'hFF, pat(255));
      for (int i = 0; i < 16; i++) begin
         if (i != 6 && i != 7) begin
            bank_rd(8'(i), v);
            if (i < NREG) chk("R3 R4 slot readback", v, pat(i));
            else          chk("R7 out-of-range slot reads 0", v, 32'h0);
         end
      end
      bank_rd(8'hFF, v); chk("R7 slot 255 reads 0", v, 32'h0);

      // R5 command while busy ignored, sticky error
      hwrite(1'b0, 32'hC000_0000);
      hwrite(1'b0, 32'h8000_0005);
      wait_idle(cyc);
      hread(1'b0, v); chk("R5 in-flight command kept, error set", v, 32'h6000_0000);
      hread(1'b1, v); chk("R5 read of slot 0 completed", v, pat(0));
      // R11 idle command without busy bit; clears error
      hwrite(1'b0, 32'h2000_0009);
      hread(1'b0, v); chk("R11 no start, R5 error cleared", v, 32'h4000_0000);
      @(negedge clk);
      hread(1'b0, v); chk("R11 busy stays 0", {31'h0, v[31]}, 32'h0);

      // R6 data write while busy dropped
      hwrite(1'b1, 32'h1234_5678);
      hwrite(1'b0, 32'h8000_0002);
      hwrite(1'b1, 32'hDEAD_BEEF);
      hread(1'b1, v); chk("R6 data reg kept during busy", v, 32'h1234_5678);
      wait_idle(cyc);
      bank_rd(8'd2, v); chk("R6 slot 2 got original data", v, 32'h1234_5678);

      // R8 R9 R10 management reads over several PHY addresses
      for (int p = 0; p < 4; p++) begin
         logic [4:0] rg;
         logic [15:0] rv;
         rg = 5'(p + 2);
         rv = {5'(p), rg, 6'h2A};
         bank_wr(8'd6, {16'h0, 5'(p), rg, 4'h0, 1'b0, 1'b1});
         chk("R8 request raised", {31'h0, mgmt_req}, 32'h1);
         chk("R8 phy field", {27'h0, mgmt_phy}, 32'(p));
         chk("R8 reg field", {27'h0, mgmt_reg}, {27'h0, rg});
         chk("R8 read direction", {31'h0, mgmt_wr}, 32'h0);
         chk("R9 on-chip select", {31'h0, mgmt_int_sel}, (p == 1) ? 32'h1 : 32'h0);
         bank_rd(8'd6, v);
         chk("R8 pending bit readable", v, {16'h0, 5'(p), rg, 4'h0, 1'b0, 1'b1});
         chk("R8 request held", {31'h0, mgmt_req}, 32'h1);
         @(negedge clk);
         mgmt_ack = 1'b1; mgmt_rdata = rv;
         @(negedge clk);
         mgmt_ack = 1'b0; mgmt_rdata = 16'h0;
         chk("R8 request released on ack", {31'h0, mgmt_req}, 32'h0);
         bank_rd(8'd7, v); chk("R10 read data captured", v, {16'h0, rv});
      end

      // R10 management write
      bank_wr(8'd7, 32'h0000_9ABC);
      bank_wr(8'd6, {16'h0, 5'd9, 5'd4, 4'h0, 1'b1, 1'b1});
      chk("R10 write direction", {31'h0, mgmt_wr}, 32'h1);
      chk("R10 write data", {16'h0, mgmt_wdata}, 32'h0000_9ABC);
      chk("R9 external select", {31'h0, mgmt_int_sel}, 32'h0);
      @(negedge clk);
      mgmt_ack = 1'b1; mgmt_rdata = 16'hFFFF;
      @(negedge clk);
      mgmt_ack = 1'b0;
      bank_rd(8'd7, v); chk("R10 write leaves data slot", v, 32'h0000_9ABC);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (100000) @(posedge clk);
            errors++;
            $display("FAIL R2 watchdog actual hung expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule